// File: doc/BRIEF.md
# Two-Operand Integer and Decimal ALU with Flag Policy

This block is the execute stage for the two-operand instruction group of a 16-bit processor core. Each cycle it takes an operation code, a byte/word select, the already-resolved source and destination operand values and the current carry, zero, negative and overflow flags. One clock later it presents the result, a destination write enable, the four next flag values and a per-flag update mask.

The group covers:

- move;
- binary add and subtract, each with and without carry;
- compare;
- BCD add;
- bit test;
- bit clear and bit set;
- exclusive-or and and.

Every operation follows its own rule on two points: which flags it changes, and whether the destination is written. Subtraction adds the inverted source to the destination, so the carry acts as an inverted borrow.

Byte mode narrows every operation to bits 7:0. Instruction fetch, operand addressing, the register file and memory lie outside the block.

Top module: `dual_operand_alu`

## Requirements
- R1: All outputs are registered. A result appears on the first rising edge after its inputs. A synchronous active-high reset drives result, dst_write, the four flag outputs and flag_upd to zero.
- R2: The operation codes are 4=move, 5=add, 6=add-with-carry, 7=subtract-with-carry, 8=subtract, 9=compare, A=decimal add, B=bit test, C=bit clear, D=bit set, E=xor and F=and. Codes 0 to 3 give result 0, no write and no flag update.
- R3: Add gives src+dst. Add-with-carry gives src+dst+C. Both write the destination and update all four flags, and C is the carry out of the active most significant bit.
- R4: Subtract gives dst+~src+1. Subtract-with-carry gives dst+~src+C. Both write the destination and update all four flags, and C=1 means no borrow.
- R5: For add, subtract and compare, V is signed overflow at the active width. For every flag-updating operation, N is the active most significant result bit and Z is set when the active-width result is zero.
- R6: Compare produces the subtract result and subtract flags on the outputs, but dst_write stays 0.
- R7: Decimal add sums src+dst+C digit by digit in BCD. C is set when the top active digit passes 9. N and Z are updated, and V is not updated.
- R8: And and bit test give src&dst, force V to 0 and set C to the inverse of Z. Bit test never writes the destination.
- R9: Xor gives src^dst. V is set when both operands are negative at the active width, and C is the inverse of Z.
- R10: Move (src), bit clear (~src&dst) and bit set (src|dst) write the destination and update no flag.
- R11: With byte_sel=1, only bits 7:0 take part. The upper result byte is 0, N comes from bit 7 and the carry comes out of bit 7.
- R12: The bits of flag_upd are [3]=V, [2]=N, [1]=Z and [0]=C. A flag output whose update bit is 0 equals that flag's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation code |
| byte_sel | input | 1 | 1 selects 8-bit operation |
| src_val | input | 16 | Source operand |
| dst_val | input | 16 | Destination operand |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| n_in | input | 1 | Current negative flag |
| v_in | input | 1 | Current overflow flag |
| result | output | 16 | Registered result |
| dst_write | output | 1 | Destination write enable |
| c_out | output | 1 | Next carry flag |
| z_out | output | 1 | Next zero flag |
| n_out | output | 1 | Next negative flag |
| v_out | output | 1 | Next overflow flag |
| flag_upd | output | 4 | Per-flag update mask {V,N,Z,C} |

## Verification
The bench aims at the carry and overflow boundaries: 7FFF+1, FFFF+1, 8000-1 and their byte versions. A design that takes the carry or the sign from the wrong bit position fails these immediately.

Subtraction is checked both with equal operands and with a borrow in. An inverted carry convention would show up there as a wrong C.

Decimal add is driven through a digit carry chain (9999+1 and 0199+1). A missing +6 correction, or V being touched, would give a wrong result or a wrong V.

The non-writing operations (compare and bit test), the flag-preserving operations and the unused codes are checked at dst_write, at flag_upd and at flag outputs that must echo their inputs.

// File: rtl/alu2_pkg.sv
package alu2_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [3:0] {
    OP_MOV  = 4'h4,
    OP_ADD  = 4'h5,
    OP_ADDC = 4'h6,
    OP_SUBC = 4'h7,
    OP_SUB  = 4'h8,
    OP_CMP  = 4'h9,
    OP_DADD = 4'hA,
    OP_BIT  = 4'hB,
    OP_BIC  = 4'hC,
    OP_BIS  = 4'hD,
    OP_XOR  = 4'hE,
    OP_AND  = 4'hF
  } alu_op_e;

  typedef enum logic [2:0] {
    FK_NONE,
    FK_ARITH,
    FK_DEC,
    FK_LOGIC,
    FK_XOR
  } flag_kind_e;

  // update mask bit positions
  localparam int UPD_C = 0;
  localparam int UPD_Z = 1;
  localparam int UPD_N = 2;
  localparam int UPD_V = 3;
endpackage

// File: rtl/alu2_binadd.sv
module alu2_binadd #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         byte_sel,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int H = W / 2;
  localparam logic [W-1:0] LOW_MASK = {{(W-H){1'b0}}, {H{1'b1}}};

  logic [W-1:0] mask, a_m, b_m;
  logic [W:0]   full;
  logic         ma, mb, mr;

  always_comb begin
    mask = byte_sel ? LOW_MASK : {W{1'b1}};
    a_m  = a & mask;
    b_m  = b & mask;
    full = {1'b0, a_m} + {1'b0, b_m} + {{W{1'b0}}, cin};
    sum  = full[W-1:0] & mask;
    cout = byte_sel ? full[H] : full[W];
    ma   = byte_sel ? a_m[H-1] : a_m[W-1];
    mb   = byte_sel ? b_m[H-1] : b_m[W-1];
    mr   = byte_sel ? full[H-1] : full[W-1];
    ovf  = (ma == mb) && (mr != ma);
  end
endmodule

// File: rtl/alu2_bcdadd.sv
module alu2_bcdadd #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         byte_sel,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int ND = W / 4;
  localparam int NB = ND / 2;
  localparam logic [W-1:0] LOW_MASK = {{(W/2){1'b0}}, {(W/2){1'b1}}};

  logic [ND:0]  dc;
  logic [W-1:0] raw;

  assign dc[0] = cin;

  for (genvar i = 0; i < ND; i++) begin : g_digit
    logic [4:0] s5, fix;
    always_comb begin
      s5  = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0, dc[i]};
      fix = s5 + 5'd6;
    end
    assign dc[i+1]      = (s5 > 5'd9);
    assign raw[4*i +: 4] = (s5 > 5'd9) ? fix[3:0] : s5[3:0];
  end

  assign sum  = byte_sel ? (raw & LOW_MASK) : raw;
  assign cout = byte_sel ? dc[NB] : dc[ND];
endmodule

// File: rtl/alu2_policy.sv
module alu2_policy
  import alu2_pkg::*;
(
  input  logic [3:0]  op,
  output logic        wr_en,
  output logic [3:0]  upd,
  output flag_kind_e  kind,
  output logic        is_sub,
  output logic        use_cin,
  output logic        const_cin
);
  always_comb begin
    wr_en     = 1'b0;
    upd       = 4'b0000;
    kind      = FK_NONE;
    is_sub    = 1'b0;
    use_cin   = 1'b0;
    const_cin = 1'b0;
    case (op)
      OP_MOV, OP_BIC, OP_BIS: wr_en = 1'b1;
      OP_ADD:  begin wr_en = 1'b1; upd = 4'b1111; kind = FK_ARITH; end
      OP_ADDC: begin wr_en = 1'b1; upd = 4'b1111; kind = FK_ARITH; use_cin = 1'b1; end
      OP_SUB:  begin wr_en = 1'b1; upd = 4'b1111; kind = FK_ARITH; is_sub = 1'b1; const_cin = 1'b1; end
      OP_SUBC: begin wr_en = 1'b1; upd = 4'b1111; kind = FK_ARITH; is_sub = 1'b1; use_cin = 1'b1; end
      OP_CMP:  begin upd = 4'b1111; kind = FK_ARITH; is_sub = 1'b1; const_cin = 1'b1; end
      OP_DADD: begin wr_en = 1'b1; upd = 4'b0111; kind = FK_DEC; use_cin = 1'b1; end
      OP_AND:  begin wr_en = 1'b1; upd = 4'b1111; kind = FK_LOGIC; end
      OP_BIT:  begin upd = 4'b1111; kind = FK_LOGIC; end
      OP_XOR:  begin wr_en = 1'b1; upd = 4'b1111; kind = FK_XOR; end
      default: ;
    endcase
  end
endmodule

// File: rtl/dual_operand_alu.sv
module dual_operand_alu
  import alu2_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_code,
  input  logic         byte_sel,
  input  logic [W-1:0] src_val,
  input  logic [W-1:0] dst_val,
  input  logic         c_in,
  input  logic         z_in,
  input  logic         n_in,
  input  logic         v_in,
  output logic [W-1:0] result,
  output logic         dst_write,
  output logic         c_out,
  output logic         z_out,
  output logic         n_out,
  output logic         v_out,
  output logic [3:0]   flag_upd
);
  localparam int H = W / 2;
  localparam logic [W-1:0] LOW_MASK = {{(W-H){1'b0}}, {H{1'b1}}};

  logic       pol_we, pol_sub, pol_usec, pol_constc;
  logic [3:0] pol_upd;
  flag_kind_e pol_kind;

  alu2_policy u_pol (
    .op(op_code), .wr_en(pol_we), .upd(pol_upd), .kind(pol_kind),
    .is_sub(pol_sub), .use_cin(pol_usec), .const_cin(pol_constc)
  );

  logic [W-1:0] add_a, add_b, add_sum, bcd_sum;
  logic         add_cin, add_cout, add_ovf, bcd_cout;

  assign add_a   = pol_sub ? dst_val : src_val;
  assign add_b   = pol_sub ? ~src_val : dst_val;
  assign add_cin = pol_usec ? c_in : pol_constc;

  alu2_binadd #(.W(W)) u_add (
    .a(add_a), .b(add_b), .cin(add_cin), .byte_sel(byte_sel),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  alu2_bcdadd #(.W(W)) u_bcd (
    .a(src_val), .b(dst_val), .cin(c_in), .byte_sel(byte_sel),
    .sum(bcd_sum), .cout(bcd_cout)
  );

  logic [W-1:0] mask, r_sel, r_act;
  logic         f_c, f_z, f_n, f_v, s_msb, d_msb;

  always_comb begin
    mask = byte_sel ? LOW_MASK : {W{1'b1}};
    case (op_code)
      OP_MOV:                          r_sel = src_val;
      OP_ADD, OP_ADDC, OP_SUB,
      OP_SUBC, OP_CMP:                 r_sel = add_sum;
      OP_DADD:                         r_sel = bcd_sum;
      OP_AND, OP_BIT:                  r_sel = src_val & dst_val;
      OP_BIC:                          r_sel = ~src_val & dst_val;
      OP_BIS:                          r_sel = src_val | dst_val;
      OP_XOR:                          r_sel = src_val ^ dst_val;
      default:                         r_sel = '0;
    endcase
    r_act = r_sel & mask;
    s_msb = byte_sel ? src_val[H-1] : src_val[W-1];
    d_msb = byte_sel ? dst_val[H-1] : dst_val[W-1];
    f_n   = byte_sel ? r_act[H-1] : r_act[W-1];
    f_z   = (r_act == '0);
    f_c   = c_in;
    f_v   = v_in;
    case (pol_kind)
      FK_ARITH: begin f_c = add_cout; f_v = add_ovf; end
      FK_DEC:   begin f_c = bcd_cout; end
      FK_LOGIC: begin f_c = ~f_z; f_v = 1'b0; end
      FK_XOR:   begin f_c = ~f_z; f_v = s_msb & d_msb; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      dst_write <= 1'b0;
      flag_upd  <= 4'b0000;
      c_out     <= 1'b0;
      z_out     <= 1'b0;
      n_out     <= 1'b0;
      v_out     <= 1'b0;
    end else begin
      result    <= r_act;
      dst_write <= pol_we;
      flag_upd  <= pol_upd;
      c_out     <= pol_upd[UPD_C] ? f_c : c_in;
      z_out     <= pol_upd[UPD_Z] ? f_z : z_in;
      n_out     <= pol_upd[UPD_N] ? f_n : n_in;
      v_out     <= pol_upd[UPD_V] ? f_v : v_in;
    end
  end

  // R11: upper byte of a byte-mode result is zero
  assert_byte_upper_R11: assert property (@(posedge clk) disable iff (rst)
    byte_sel |=> result[W-1:H] == '0);

  // R6: compare updates all flags and never writes
  assert_cmp_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_CMP) |=> (!dst_write && flag_upd == 4'b1111));

  // R8: and / bit test clear V and tie C to not-Z
  assert_logic_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_AND || op_code == OP_BIT) |=> (!v_out && c_out == !z_out));

  // R10: move keeps every flag as it came in
  assert_mov_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_MOV) |=> (flag_upd == 4'b0000 && dst_write &&
      c_out == $past(c_in) && z_out == $past(z_in) &&
      n_out == $past(n_in) && v_out == $past(v_in)));

  // R2: unused codes neither write nor update
  assert_unused_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (op_code < 4'h4) |=> (!dst_write && flag_upd == 4'b0000 && result == '0));

  // R7: decimal add leaves V as it came in
  assert_dadd_v_R7: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_DADD) |=> (v_out == $past(v_in) && !flag_upd[UPD_V]));
endmodule

// File: tb/sim_dual_operand_alu.sv
module sim_dual_operand_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op_code;
  logic        byte_sel;
  logic [15:0] src_val, dst_val;
  logic        c_in, z_in, n_in, v_in;
  logic [15:0] result;
  logic        dst_write, c_out, z_out, n_out, v_out;
  logic [3:0]  flag_upd;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_operand_alu u0 (
    .clk(clk), .rst(rst), .op_code(op_code), .byte_sel(byte_sel),
    .src_val(src_val), .dst_val(dst_val),
    .c_in(c_in), .z_in(z_in), .n_in(n_in), .v_in(v_in),
    .result(result), .dst_write(dst_write),
    .c_out(c_out), .z_out(z_out), .n_out(n_out), .v_out(v_out),
    .flag_upd(flag_upd)
  );

  // {op, byte, src, dst, flags_in{V,N,Z,C}, exp_result, exp_we, exp_flags{V,N,Z,C}, exp_upd}
  localparam int NV = 24;
  localparam logic [65:0] VEC [NV] = '{
    {4'h5,1'b0,16'h7FFF,16'h0001,4'b0000,16'h8000,1'b1,4'b1100,4'b1111}, // R3 R5 overflow
    {4'h5,1'b0,16'hFFFF,16'h0001,4'b0000,16'h0000,1'b1,4'b0011,4'b1111}, // R3 carry out
    {4'h6,1'b0,16'h1234,16'h1111,4'b0001,16'h2346,1'b1,4'b0000,4'b1111}, // R3 carry in
    {4'h8,1'b0,16'h0001,16'h0000,4'b0000,16'hFFFF,1'b1,4'b0100,4'b1111}, // R4 borrow
    {4'h8,1'b0,16'h0005,16'h0005,4'b0000,16'h0000,1'b1,4'b0011,4'b1111}, // R4 equal
    {4'h7,1'b0,16'h0001,16'h0003,4'b0000,16'h0001,1'b1,4'b0001,4'b1111}, // R4 borrow in
    {4'h8,1'b0,16'h0001,16'h8000,4'b0000,16'h7FFF,1'b1,4'b1001,4'b1111}, // R4 R5 overflow
    {4'h9,1'b0,16'h0003,16'h0005,4'b0000,16'h0002,1'b0,4'b0001,4'b1111}, // R6
    {4'hA,1'b0,16'h0199,16'h0001,4'b1000,16'h0200,1'b1,4'b1000,4'b0111}, // R7 chain
    {4'hA,1'b0,16'h9999,16'h0001,4'b0000,16'h0000,1'b1,4'b0011,4'b0111}, // R7 overflow
    {4'hF,1'b0,16'hF0F0,16'hFF00,4'b1000,16'hF000,1'b1,4'b0101,4'b1111}, // R8 and
    {4'hB,1'b0,16'h00FF,16'hFF00,4'b0000,16'h0000,1'b0,4'b0010,4'b1111}, // R8 bit test
    {4'hE,1'b0,16'h8001,16'h8003,4'b0000,16'h0002,1'b1,4'b1001,4'b1111}, // R9
    {4'h4,1'b0,16'hABCD,16'h1234,4'b1010,16'hABCD,1'b1,4'b1010,4'b0000}, // R10 move
    {4'hC,1'b0,16'h00F0,16'h0FFF,4'b0101,16'h0F0F,1'b1,4'b0101,4'b0000}, // R10 clear
    {4'hD,1'b0,16'h1000,16'h0001,4'b0000,16'h1001,1'b1,4'b0000,4'b0000}, // R10 set
    {4'h5,1'b1,16'h12FF,16'h3401,4'b0000,16'h0000,1'b1,4'b0011,4'b1111}, // R11 carry bit7
    {4'h5,1'b1,16'h007F,16'h0001,4'b0000,16'h0080,1'b1,4'b1100,4'b1111}, // R11 overflow
    {4'h8,1'b1,16'h0001,16'hFF00,4'b0000,16'h00FF,1'b1,4'b0100,4'b1111}, // R11 sub
    {4'hA,1'b1,16'h0055,16'h0045,4'b0001,16'h0001,1'b1,4'b0001,4'b0111}, // R11 R7
    {4'hE,1'b1,16'hAA80,16'h5580,4'b0000,16'h0000,1'b1,4'b1010,4'b1111}, // R11 R9
    {4'h4,1'b1,16'hABCD,16'h0000,4'b0110,16'h00CD,1'b1,4'b0110,4'b0000}, // R11 R10
    {4'h3,1'b0,16'h1234,16'h5678,4'b1111,16'h0000,1'b0,4'b1111,4'b0000}, // R2 R12
    {4'h7,1'b0,16'h0000,16'h0000,4'b0000,16'hFFFF,1'b1,4'b0100,4'b1111}  // R4 subc
  };

  function automatic string req_of(input logic [3:0] op, input logic bw);
    string s;
    case (op)
      4'h5, 4'h6: s = "R3";
      4'h7, 4'h8: s = "R4";
      4'h9:       s = "R6";
      4'hA:       s = "R7";
      4'hB, 4'hF: s = "R8";
      4'hE:       s = "R9";
      4'h4, 4'hC, 4'hD: s = "R10";
      default:    s = "R2";
    endcase
    if (bw) s = {s, "/R11"};
    return s;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic bw, input logic [15:0] s,
                       input logic [15:0] d, input logic [3:0] f);
    op_code = op; byte_sel = bw; src_val = s; dst_val = d;
    {v_in, n_in, z_in, c_in} = f;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(4'h5, 1'b0, 16'hFFFF, 16'hFFFF, 4'b1111);
    repeat (3) @(posedge clk);
    #2;
    // R1: reset values
    check("R1", "reset result", {16'h0, result}, 32'h0);
    check("R1", "reset we/flags/upd", {23'h0, dst_write, v_out, n_out, z_out, c_out, flag_upd}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // R1: one-cycle latency, outputs hold until the edge
    drive(4'h4, 1'b0, 16'h5A5A, 16'h0, 4'b0000);
    @(posedge clk); #2;
    check("R1", "move after one edge", {16'h0, result}, 32'h5A5A);
    @(negedge clk);
    drive(4'h4, 1'b0, 16'h1111, 16'h0, 4'b0000);
    #2;
    check("R1", "no change before edge", {16'h0, result}, 32'h5A5A);

    for (int i = 0; i < NV; i++) begin
      logic [65:0] v;
      v = VEC[i];
      @(negedge clk);
      drive(v[65:62], v[61], v[60:45], v[44:29], v[28:25]);
      @(posedge clk); #2;
      check(req_of(v[65:62], v[61]), $sformatf("vec%0d result", i), {16'h0, result}, {16'h0, v[24:9]});
      check(req_of(v[65:62], v[61]), $sformatf("vec%0d dst_write", i), {31'h0, dst_write}, {31'h0, v[8]});
      check(req_of(v[65:62], v[61]), $sformatf("vec%0d flags VNZC", i),
            {28'h0, v_out, n_out, z_out, c_out}, {28'h0, v[7:4]});
      check("R12", $sformatf("vec%0d flag_upd", i), {28'h0, flag_upd}, {28'h0, v[3:0]});
    end

    // R2 R12: unused codes echo every flag pattern
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      drive(k[1:0], k[2], 16'hFFFF, 16'hFFFF, k[3:0]);
      @(posedge clk); #2;
      check("R2", "unused code result/we", {15'h0, dst_write, result}, 32'h0);
      check("R12", "unused code flag echo", {24'h0, flag_upd, v_out, n_out, z_out, c_out},
            {24'h0, 4'b0000, k[3:0]});
    end

    // R5: word compare negative result with overflow, 0x7FFF - 0xFFFF
    @(negedge clk);
    drive(4'h9, 1'b0, 16'hFFFF, 16'h7FFF, 4'b0000);
    @(posedge clk); #2;
    check("R5", "cmp overflow flags", {28'h0, v_out, n_out, z_out, c_out}, {28'h0, 4'b1100});

    // R1: reset mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    drive(4'h5, 1'b0, 16'h0001, 16'h0001, 4'b1111);
    @(posedge clk); #2;
    check("R1", "reset mid-run", {15'h0, dst_write, result}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule